// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a small byte-addressed memory reached over a two-wire serial bus. Clock and data lines are oversampled in the system clock domain. The block detects start and stop conditions and shifts address and data bytes in on rising clock edges. It acknowledges bytes by pulling the data line low through an open-drain enable, and shifts read data out MSB first while the clock is low.

Written bytes are first held in a page-sized staging buffer. After the closing stop condition, a timed internal programming cycle copies them into a 256-byte register array. While that cycle runs, the busy output is high and the slave acknowledges nothing on the bus. If a write sends more bytes than a page holds, the page offset wraps, so the most recent bytes replace the older ones at the same offsets.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, sda_oe_o and busy_o are 0, the address pointer is 0 and every memory byte reads as 0x00.
- R2: The first byte after a start is a 7-bit select followed by a direction bit (1 = read). The select is sent MSB first. Select 1010000 is acknowledged by holding SDA low through the ninth clock pulse. Any other select is not acknowledged, and every byte up to the next start is then ignored, including bytes that would otherwise match.
- R3: The slave changes SDA only while SCL is low. SDA stays stable through every SCL high phase in which the slave drives it.
- R4: In a write, the second byte loads the address pointer. Each later data byte is acknowledged and lands at the address whose upper 4 bits are those of the pointer and whose lower 4 bits start at the pointer's lower bits and wrap within the 16-byte page.
- R5: When more than 16 data bytes are written, a later byte replaces the earlier byte at the same page offset, so the last 16 bytes are the ones stored.
- R6: A stop that ends a write carrying at least one data byte raises busy_o in the following cycles for exactly PROG_CYCLES clocks. While busy_o is high, no byte is acknowledged, its own select included.
- R7: A read returns the byte at the address pointer, MSB first, and then increments the pointer. The pointer wraps from 0xFF to 0x00. Consecutive bytes follow while the master acknowledges.
- R8: When the master does not acknowledge a read byte, the slave leaves SDA released until the next start or stop.
- R9: A write that is cut off by a repeated start, or that stops without a data byte, changes only the pointer. Memory is left unchanged and busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous to clk_i |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| busy_o | output | 1 | High while the internal programming cycle runs |

## Verification
A wrong bit counter or protocol state shows up within one byte time: an acknowledge is missing or misplaced on the ninth pulse, or a read byte is shifted. Staging or commit faults stay hidden until the programming cycle ends and the page is read back. A write offset error therefore appears only as wrong bytes at particular page positions, and the overflow and wrap cases place data at known offsets so those positions can be checked. A timer fault shows as a busy pulse of the wrong length, and a select that is acknowledged during that pulse shows a missing busy gate.

// File: rtl/twi_mem_pkg.sv
`timescale 1ns/1ps
package twi_mem_pkg;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_ADDR,
    PH_WDAT,
    PH_ACK,
    PH_RDAT,
    PH_MACK,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/twi_line_mon.sv
`timescale 1ns/1ps
module twi_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] scl_sh, sda_sh;

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SW-2:0], scl_i};
      sda_sh <= {sda_sh[SW-2:0], sda_i};
    end
  end

  logic scl_q, scl_p, sda_q, sda_p;
  assign scl_q = scl_sh[SW-2];
  assign scl_p = scl_sh[SW-1];
  assign sda_q = sda_sh[SW-2];
  assign sda_p = sda_sh[SW-1];

  assign scl_o      = scl_q;
  assign sda_o      = sda_q;
  assign scl_rise_o = scl_q & ~scl_p;
  assign scl_fall_o = ~scl_q & scl_p;
  assign start_o    = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_o     = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/twi_page_stage.sv
`timescale 1ns/1ps
module twi_page_stage #(
  parameter int PAGE   = 16,
  parameter int BYTE_W = 8,
  localparam int OW    = $clog2(PAGE)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic [OW-1:0]                base_i,
  input  logic                         push_i,
  input  logic [BYTE_W-1:0]            data_i,
  output logic [PAGE-1:0][BYTE_W-1:0]  slot_data_o,
  output logic [PAGE-1:0]              slot_vld_o
);
  logic [PAGE-1:0][BYTE_W-1:0] data_q;
  logic [PAGE-1:0]             vld_q;
  logic [OW-1:0]               off_q;

  // slot index is the page offset, so a wrap overwrites the oldest byte in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= '0;
      off_q  <= '0;
    end else if (clear_i) begin
      vld_q <= '0;
      off_q <= base_i;
    end else if (push_i) begin
      data_q[off_q] <= data_i;
      vld_q[off_q]  <= 1'b1;
      off_q         <= off_q + 1'b1;
    end
  end

  assign slot_data_o = data_q;
  assign slot_vld_o  = vld_q;
endmodule

// File: rtl/twi_prog_store.sv
`timescale 1ns/1ps
module twi_prog_store #(
  parameter int ADDR_W      = 8,
  parameter int BYTE_W      = 8,
  parameter int PAGE        = 16,
  parameter int PROG_CYCLES = 64,
  localparam int OW         = $clog2(PAGE),
  localparam int DEPTH      = 1 << ADDR_W,
  localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [ADDR_W-OW-1:0]         page_i,
  input  logic [PAGE-1:0][BYTE_W-1:0]  slot_data_i,
  input  logic [PAGE-1:0]              slot_vld_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [BYTE_W-1:0]            rd_data_o,
  output logic                         busy_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic              busy_q;
  logic [CW-1:0]     tmr_q;
  logic [OW:0]       walk_q;
  logic [OW-1:0]     slot;

  assign slot = walk_q[OW-1:0];

  // timer sets busy length; slots are copied one per clock at its start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      walk_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      tmr_q  <= CW'(PROG_CYCLES - 1);
      walk_q <= '0;
    end else if (busy_q) begin
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
      if (!walk_q[OW]) walk_q <= walk_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (busy_q && !walk_q[OW] && slot_vld_i[slot]) begin
      mem_q[{page_i, slot}] <= slot_data_i[slot];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign busy_o    = busy_q;
endmodule

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int         PAGE        = 16,
  parameter int         PROG_CYCLES = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ID      = 7'b1010000,
  localparam int        OW          = $clog2(PAGE)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic busy_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;

  twi_line_mon #(.SYNC_STAGES(SYNC_STAGES)) i_line_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_s),
    .stop_o     (stop_s)
  );

  phase_e              state_q, nxt_q;
  logic [3:0]          bit_q;
  logic [BYTE_W-1:0]   rx_q, tx_q, rd_data;
  logic [ADDR_W-1:0]   ptr_q;
  logic                oe_q, mnack_q, dirty_q;
  logic                byte_done, sel_hit, stage_clr, stage_push, commit;
  logic [PAGE-1:0][BYTE_W-1:0] slot_data;
  logic [PAGE-1:0]     slot_vld;

  assign byte_done  = scl_fall && (bit_q == 4'd8);
  assign sel_hit    = (rx_q[7:1] == DEV_ID) && !busy_o;
  assign stage_clr  = byte_done && (state_q == PH_ADDR);
  assign stage_push = byte_done && (state_q == PH_WDAT);
  assign commit     = stop_s && dirty_q && !busy_o;

  twi_page_stage #(.PAGE(PAGE), .BYTE_W(BYTE_W)) i_page_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (stage_clr),
    .base_i      (rx_q[OW-1:0]),
    .push_i      (stage_push),
    .data_i      (rx_q),
    .slot_data_o (slot_data),
    .slot_vld_o  (slot_vld)
  );

  twi_prog_store #(
    .ADDR_W      (ADDR_W),
    .BYTE_W      (BYTE_W),
    .PAGE        (PAGE),
    .PROG_CYCLES (PROG_CYCLES)
  ) i_prog_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (commit),
    .page_i      (ptr_q[ADDR_W-1:OW]),
    .slot_data_i (slot_data),
    .slot_vld_i  (slot_vld),
    .rd_addr_i   (ptr_q),
    .rd_data_o   (rd_data),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      nxt_q   <= PH_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      mnack_q <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      unique case (state_q)
        PH_SEL, PH_ADDR, PH_WDAT: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
            bit_q <= bit_q + 1'b1;
          end
          if (byte_done) begin
            bit_q <= '0;
            if (state_q == PH_SEL) begin
              if (sel_hit) begin
                oe_q    <= 1'b1;
                state_q <= PH_ACK;
                nxt_q   <= rx_q[0] ? PH_RDAT : PH_ADDR;
              end else begin
                state_q <= PH_SKIP;
              end
            end else begin
              oe_q    <= 1'b1;
              state_q <= PH_ACK;
              nxt_q   <= PH_WDAT;
              if (state_q == PH_ADDR) ptr_q   <= rx_q;
              else                    dirty_q <= 1'b1;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bit_q <= '0;
            if (nxt_q == PH_RDAT) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              ptr_q   <= ptr_q + 1'b1;
              state_q <= PH_RDAT;
            end else begin
              oe_q    <= 1'b0;
              state_q <= nxt_q;
            end
          end
        end
        PH_RDAT: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= PH_MACK;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
              oe_q  <= ~tx_q[BYTE_W-2];
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) mnack_q <= sda_s;
          if (scl_fall) begin
            bit_q <= '0;
            if (!mnack_q) begin
              tx_q    <= rd_data;
              oe_q    <= ~rd_data[BYTE_W-1];
              ptr_q   <= ptr_q + 1'b1;
              state_q <= PH_RDAT;
            end else begin
              state_q <= PH_SKIP;
            end
          end
        end
        default: ;
      endcase

      // bus conditions override the byte phases
      if (start_s) begin
        state_q <= PH_SEL;
        bit_q   <= '0;
        oe_q    <= 1'b0;
        dirty_q <= 1'b0;
      end else if (stop_s) begin
        state_q <= PH_IDLE;
        bit_q   <= '0;
        oe_q    <= 1'b0;
        dirty_q <= 1'b0;
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/twi_mem_slave_chk.sv
`timescale 1ns/1ps
module twi_mem_slave_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic stop_s,
  input logic sda_oe_o,
  input logic busy_o
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= 0;
    else if (busy_o) hi_cnt <= hi_cnt + 1;
    else             hi_cnt <= 0;
  end

  // R3
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

  // R6
  no_ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  // R6
  busy_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_s));

  // R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (hi_cnt == PROG_CYCLES));
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) i_twi_mem_slave_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .stop_s   (stop_s),
  .sda_oe_o (sda_oe_o),
  .busy_o   (busy_o)
);

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;
  localparam int Q    = 10;
  localparam int PROG = 800;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe_o, busy_o;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe_o;

  always #2 clk_i = ~clk_i;

  twi_mem_slave #(.PROG_CYCLES(PROG)) i_twi_mem_slave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe_o),
    .busy_o   (busy_o)
  );

  int checks = 0, errors = 0, unstable = 0, busy_run = 0, last_len = 0;
  logic [7:0] wbuf [32];
  logic [7:0] rexp [32];

  always @(negedge clk_i) begin
    if (busy_o) busy_run++;
    else if (busy_run != 0) begin
      last_len = busy_run;
      busy_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    logic s1, s2;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    s1 = sda_line; wq();
    s2 = sda_line; scl_m = 1'b0; wq();
    if (s1 != s2) unstable++;
    b = s1;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~m_ack);
  endtask

  task automatic wait_ready();
    wq();
    while (busy_o) @(negedge clk_i);
    wq();
  endtask

  task automatic write_seq(input logic [7:0] addr, input int n);
    logic a;
    int acks = 0;
    bus_start();
    send_byte(8'hA0, a); acks += int'(a);
    send_byte(addr, a);  acks += int'(a);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a);
      acks += int'(a);
    end
    chk(acks == n + 2, "R4 write acks", acks, n + 2);
    bus_stop();
  endtask

  task automatic read_at(input logic [7:0] addr, input int n, input string req, input bit probe);
    logic a;
    logic b;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA0, a);
    send_byte(addr, a);
    bus_start();
    send_byte(8'hA1, a);
    chk(a, "R2 read select ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      chk(d == rexp[k], req, int'(d), int'(rexp[k]));
    end
    if (probe) begin
      recv_bit(b);
      chk(b == 1'b1, "R8 released after nack", int'(b), 1);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    logic a;
    logic [7:0] d;
    chk(sda_oe_o == 1'b0, "R1 oe", int'(sda_oe_o), 0);
    chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
    bus_start();
    send_byte(8'hA1, a);
    chk(a, "R2 select ack", int'(a), 1);
    recv_byte(1'b0, d);
    chk(d == 8'h00, "R1 mem at pointer 0", int'(d), 0);
    bus_stop();
  endtask

  task automatic t_bad_select();
    logic a;
    bus_start();
    send_byte(8'hA2, a);
    chk(!a, "R2 wrong select nack", int'(a), 0);
    send_byte(8'hA0, a);
    chk(!a, "R2 ignored until start", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte(8'hA0, a);
    chk(a, "R2 recovered after start", int'(a), 1);
    bus_stop();
  endtask

  task automatic t_write_read();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_seq(8'h10, 3);
    wait_ready();
    chk(last_len == PROG, "R6 busy length", last_len, PROG);
    rexp[0] = 8'h11; rexp[1] = 8'h22; rexp[2] = 8'h33;
    read_at(8'h10, 3, "R7 sequential read", 1'b1);
  endtask

  task automatic t_page_wrap();
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
    write_seq(8'h2E, 4);
    wait_ready();
    rexp[0] = 8'hA0; rexp[1] = 8'hA1; rexp[2] = 8'h00;
    read_at(8'h2E, 3, "R4 page wrap upper", 1'b0);
    rexp[0] = 8'hA2; rexp[1] = 8'hA3;
    read_at(8'h20, 2, "R4 page wrap lower", 1'b0);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 18; k++) wbuf[k] = 8'h80 + 8'(k);
    write_seq(8'h40, 18);
    wait_ready();
    for (int j = 0; j < 16; j++) rexp[j] = (j < 2) ? 8'h90 + 8'(j) : 8'h80 + 8'(j);
    read_at(8'h40, 16, "R5 last 16 kept", 1'b0);
  endtask

  task automatic t_busy();
    logic a;
    wbuf[0] = 8'h77;
    write_seq(8'h60, 1);
    chk(busy_o == 1'b1, "R6 busy after stop", int'(busy_o), 1);
    bus_start();
    send_byte(8'hA0, a);
    chk(!a, "R6 nack while busy", int'(a), 0);
    chk(busy_o == 1'b1, "R6 still busy", int'(busy_o), 1);
    bus_stop();
    wait_ready();
    chk(last_len == PROG, "R6 busy length", last_len, PROG);
    rexp[0] = 8'h77;
    read_at(8'h60, 1, "R6 data committed", 1'b0);
  endtask

  task automatic t_pointer();
    logic a;
    logic [7:0] d;
    wbuf[0] = 8'h5A;
    write_seq(8'hFF, 1);
    wait_ready();
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'hFF, a);
    bus_stop();
    wq(3);
    chk(busy_o == 1'b0, "R9 no data no busy", int'(busy_o), 0);
    bus_start();
    send_byte(8'hA1, a);
    recv_byte(1'b1, d);
    chk(d == 8'h5A, "R7 current address", int'(d), 8'h5A);
    recv_byte(1'b0, d);
    chk(d == 8'h00, "R7 pointer wrap", int'(d), 0);
    bus_stop();
    bus_start();
    send_byte(8'hA0, a);
    send_byte(8'h70, a);
    send_byte(8'h99, a);
    bus_start();
    send_byte(8'hA1, a);
    recv_byte(1'b0, d);
    chk(d == 8'h00, "R9 repeated start read", int'(d), 0);
    bus_stop();
    wq(3);
    chk(busy_o == 1'b0, "R9 no commit", int'(busy_o), 0);
    rexp[0] = 8'h00;
    read_at(8'h70, 1, "R9 memory unchanged", 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wq();
    rst_ni = 1'b1;
    wq();
    t_reset();
    t_bad_select();
    t_write_read();
    t_page_wrap();
    t_overflow();
    t_busy();
    t_pointer();
    chk(unstable == 0, "R3 SDA stable while SCL high", unstable, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule